// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-up to a usable state, then hands the command bus to the normal controller. A single `start` pulse begins the run. The block waits a fixed power-up interval, which is derived from the clock frequency. It then walks a fixed list of commands on the chip-select/RAS/CAS/WE pins, leaving a run of deselected cycles between commands. The list ends with a mode-register load. Auto-refresh is held off throughout.

The mode-register byte comes from static configuration: a 2-bit CAS-latency field, a clock-speed select and a bus-width select. The CAS-latency field is read differently at each speed grade. A nonzero override byte replaces the computed value.

Some devices only come up reliably when initialized twice. For that reason the complete pass, including its power-up wait, runs twice before `init_done` rises. Between the passes the normal refresh setting is briefly restored.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high and after it falls, with no `start` pulse, the pins stay deselected (`sd_cs_n`, `sd_ras_n`, `sd_cas_n`, `sd_we_n` all 1), and `init_done` and `refresh_en` are 0. Reset is synchronous and active high.
- R2: Before the first command of each pass, at least CLK_MHZ*WAIT_US cycles pass with the pins deselected.
- R3: Each pass issues 20 commands in this order: precharge-all, NOP, then eight times auto-refresh followed by NOP, then mode-register load, NOP. Pin codes are given as {ras_n,cas_n,we_n} with cs_n=0: NOP=111, mode load=000, auto-refresh=001, precharge=010. The internal 2-bit codes are NOP=0, mode load=1, refresh=2, precharge=3.
- R4: Between two successive commands within a pass there are at least GAP_CYC (default 5) deselected cycles.
- R5: Exactly two passes run, which is 40 commands in total. `init_done` then rises.
- R6: `refresh_en` is 0 from `start` through the last command of each pass. After each pass it shows `cfg_refresh_on` for at least one cycle. After completion it stays equal to `cfg_refresh_on`.
- R7: With a 32-bit bus (`cfg_wide_bus`=1) and no override, the mode byte is 0x40 for CL=2 and 0x60 for CL=3. CL=2 means field 0 when `cfg_fast_clk`=1, or field 1 when `cfg_fast_clk`=0. Every other field value means CL=3.
- R8: With a 16-bit bus (`cfg_wide_bus`=0) and no override, the mode byte is the 32-bit value shifted right by one: 0x20 for CL=2 and 0x30 for CL=3.
- R9: A nonzero `cfg_mode_ovr` is used unchanged as the mode byte, with no shift for a 16-bit bus.
- R10: During the mode-register load, `sd_addr[7:0]` carries the mode byte, and the remaining address bits and `sd_ba` are 0. During precharge-all, `sd_addr[10]` is 1.
- R11: Once `init_done` is high it stays high and no further command is issued, even if `start` pulses again, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the sequence when idle |
| cfg_cl_field | input | 2 | CAS-latency select field |
| cfg_fast_clk | input | 1 | 1 = fast (100 MHz) grade, 0 = slow (50 MHz) grade |
| cfg_wide_bus | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| cfg_mode_ovr | input | 8 | Mode byte override; 0 = compute |
| cfg_refresh_on | input | 1 | Normal refresh setting to restore |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus |
| sd_ba | output | BA_W | Bank address |
| refresh_en | output | 1 | Auto-refresh enable toward the controller |
| init_done | output | 1 | Initialization complete, sticky |

## Verification
Some properties are checked by assertions on every cycle. No command ever appears while refresh is enabled. The minimum deselected gap between commands always holds. A mode load always carries the selected or overriding byte, and a precharge always sets the all-banks bit. Completion is sticky and quiet.

Other properties need the bench's scenarios. These are the complete command order and count across both passes, the length of the power-up wait, and the brief restore of the refresh setting between passes. They also include the mode-byte value for each of the eight CAS-latency, speed and width combinations, override handling, and reset in the middle of a run.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    localparam int unsigned MODE_W = 8;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_MRS = 2'd1,
        CMD_REF = 2'd2,
        CMD_PRE = 2'd3
    } init_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ISSUE,
        ST_GAP,
        ST_RESTORE,
        ST_DONE
    } seq_state_e;

    // Pin pattern for a command; inactive slots deselect the device.
    function automatic pin_cmd_t encode_pins(input logic active, input init_cmd_e c);
        pin_cmd_t p;
        p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        if (active) begin
            unique case (c)
                CMD_NOP: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
                CMD_MRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
                CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
                CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
                default: p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            endcase
        end
        return p;
    endfunction

    // Computed mode byte: CL decode depends on speed grade, narrow bus halves it.
    function automatic logic [MODE_W-1:0] calc_mode(input logic [1:0] cl_field,
                                                    input logic       fast_clk,
                                                    input logic       wide_bus);
        logic             lat_two;
        logic [MODE_W-1:0] v;
        lat_two = fast_clk ? (cl_field == 2'd0) : (cl_field == 2'd1);
        v       = lat_two ? 8'h40 : 8'h60;
        if (!wide_bus) v = v >> 1;
        return v;
    endfunction

endpackage

// File: rtl/sdram_init_mode.sv
module sdram_init_mode
    import sdram_init_pkg::*;
(
    input  logic [1:0]        cl_field,
    input  logic              fast_clk,
    input  logic              wide_bus,
    input  logic [MODE_W-1:0] mode_ovr,
    output logic [MODE_W-1:0] mode_byte
);

    logic [MODE_W-1:0] computed;

    always_comb begin
        computed  = calc_mode(cl_field, fast_clk, wide_bus);
        mode_byte = (mode_ovr != '0) ? mode_ovr : computed;
    end

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
    import sdram_init_pkg::*;
#(
    parameter int unsigned WAIT_CYC      = 20000,
    parameter int unsigned GAP_CYC       = 5,
    parameter int unsigned REFRESH_COUNT = 8,
    parameter int unsigned PASSES        = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output logic      cmd_valid,
    output init_cmd_e cmd,
    output logic      refresh_allow,
    output logic      done
);

    localparam int unsigned CNT_MAX  = (WAIT_CYC > GAP_CYC) ? WAIT_CYC : GAP_CYC;
    localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);
    localparam int unsigned LIST_LEN = 2 * (REFRESH_COUNT + 2);
    localparam int unsigned IDX_W    = $clog2(LIST_LEN);
    localparam int unsigned PASS_W   = $clog2(PASSES + 1);

    localparam logic [CNT_W-1:0]  WAIT_LOAD = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0]  GAP_LOAD  = CNT_W'(GAP_CYC - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(LIST_LEN - 1);
    localparam logic [IDX_W-1:0]  MRS_IDX   = IDX_W'(LIST_LEN - 2);
    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1);

    seq_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [PASS_W-1:0] pass;

    // Command list is generated from the index: PRE, then alternating
    // command/NOP, refresh in every even slot except the mode load.
    function automatic init_cmd_e list_cmd(input logic [IDX_W-1:0] i);
        if (i == '0)           return CMD_PRE;
        else if (i[0])         return CMD_NOP;
        else if (i == MRS_IDX) return CMD_MRS;
        else                   return CMD_REF;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            pass  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_WAIT;
                        cnt   <= WAIT_LOAD;
                        pass  <= '0;
                    end
                end
                ST_WAIT: begin
                    if (cnt == '0) begin
                        state <= ST_ISSUE;
                        idx   <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_ISSUE: begin
                    if (idx == LAST_IDX) begin
                        state <= ST_RESTORE;
                    end else begin
                        state <= ST_GAP;
                        cnt   <= GAP_LOAD;
                    end
                end
                ST_GAP: begin
                    if (cnt == '0) begin
                        state <= ST_ISSUE;
                        idx   <= idx + 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_RESTORE: begin
                    if (pass == LAST_PASS) begin
                        state <= ST_DONE;
                    end else begin
                        pass  <= pass + 1'b1;
                        state <= ST_WAIT;
                        cnt   <= WAIT_LOAD;
                    end
                end
                ST_DONE: state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_valid     = (state == ST_ISSUE);
        cmd           = list_cmd(idx);
        refresh_allow = (state == ST_RESTORE) || (state == ST_DONE);
        done          = (state == ST_DONE);
    end

    // R5: completion is sticky
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R2: the first command of a pass always follows the power-up wait
    a_r2_wait_first: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ISSUE && idx == '0) |-> $past(state) == ST_WAIT);

    // R5: pass counter never runs past the configured number of passes
    always_ff @(posedge clk) begin
        if (!rst) begin
            a_r5_pass_bound: assert (pass <= LAST_PASS)
                else $error("pass counter out of range");
        end
    end

endmodule

// File: rtl/sdram_init_drv.sv
module sdram_init_drv
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned BA_W   = 2,
    parameter int unsigned AP_BIT = 10
) (
    input  logic              cmd_valid,
    input  init_cmd_e         cmd,
    input  logic [MODE_W-1:0] mode_byte,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);

    pin_cmd_t pins;
    logic     is_mrs;
    logic     is_pre;

    always_comb begin
        pins   = encode_pins(cmd_valid, cmd);
        is_mrs = cmd_valid && (cmd == CMD_MRS);
        is_pre = cmd_valid && (cmd == CMD_PRE);
        cs_n   = pins.cs_n;
        ras_n  = pins.ras_n;
        cas_n  = pins.cas_n;
        we_n   = pins.we_n;
        ba     = '0;
    end

    for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
        if (i < MODE_W) begin : g_mode_bit
            assign addr[i] = is_mrs ? mode_byte[i] : 1'b0;
        end else if (i == AP_BIT) begin : g_ap_bit
            assign addr[i] = is_pre;
        end else begin : g_zero_bit
            assign addr[i] = 1'b0;
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ       = 100,
    parameter int unsigned WAIT_US       = 200,
    parameter int unsigned GAP_CYC       = 5,
    parameter int unsigned REFRESH_COUNT = 8,
    parameter int unsigned PASSES        = 2,
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned BA_W          = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        cfg_cl_field,
    input  logic              cfg_fast_clk,
    input  logic              cfg_wide_bus,
    input  logic [7:0]        cfg_mode_ovr,
    input  logic              cfg_refresh_on,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              refresh_en,
    output logic              init_done
);

    localparam int unsigned WAIT_CYC = CLK_MHZ * WAIT_US;
    localparam int unsigned AP_BIT   = 10;
    localparam int unsigned GAP_W    = $clog2(GAP_CYC + 2);

    logic              cmd_valid;
    init_cmd_e         cmd;
    logic              refresh_allow;
    logic [MODE_W-1:0] mode_byte;

    sdram_init_mode u_mode (
        .cl_field (cfg_cl_field),
        .fast_clk (cfg_fast_clk),
        .wide_bus (cfg_wide_bus),
        .mode_ovr (cfg_mode_ovr),
        .mode_byte(mode_byte)
    );

    sdram_init_ctrl #(
        .WAIT_CYC     (WAIT_CYC),
        .GAP_CYC      (GAP_CYC),
        .REFRESH_COUNT(REFRESH_COUNT),
        .PASSES       (PASSES)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .cmd_valid    (cmd_valid),
        .cmd          (cmd),
        .refresh_allow(refresh_allow),
        .done         (init_done)
    );

    sdram_init_drv #(
        .ADDR_W(ADDR_W),
        .BA_W  (BA_W),
        .AP_BIT(AP_BIT)
    ) u_drv (
        .cmd_valid(cmd_valid),
        .cmd      (cmd),
        .mode_byte(mode_byte),
        .cs_n     (sd_cs_n),
        .ras_n    (sd_ras_n),
        .cas_n    (sd_cas_n),
        .we_n     (sd_we_n),
        .addr     (sd_addr),
        .ba       (sd_ba)
    );

    assign refresh_en = refresh_allow & cfg_refresh_on;

    // ---------------- checks on the pin stream ----------------
    logic pin_mrs;
    logic pin_pre;
    assign pin_mrs = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;
    assign pin_pre = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;

    // R6: refresh never enabled while a command is on the pins
    a_r6_refresh_off: assert property (@(posedge clk) disable iff (rst)
        !sd_cs_n |-> !refresh_en);

    // R10: mode load carries the selected byte
    a_r10_mrs_byte: assert property (@(posedge clk) disable iff (rst)
        pin_mrs |-> (sd_addr[7:0] == mode_byte && sd_ba == '0));

    // R9: a nonzero override reaches the pins unchanged
    a_r9_override: assert property (@(posedge clk) disable iff (rst)
        (pin_mrs && cfg_mode_ovr != 8'h00) |-> sd_addr[7:0] == cfg_mode_ovr);

    // R10: precharge addresses all banks
    a_r10_pre_all: assert property (@(posedge clk) disable iff (rst)
        pin_pre |-> sd_addr[AP_BIT]);

    // R11: nothing is issued once complete
    a_r11_quiet_done: assert property (@(posedge clk) disable iff (rst)
        init_done |-> sd_cs_n);

    // R4: minimum deselected run between commands, tracked by a counter
    logic [GAP_W-1:0] idle_run;
    logic             seen_cmd;
    always_ff @(posedge clk) begin
        if (rst) begin
            idle_run <= '0;
            seen_cmd <= 1'b0;
        end else if (!sd_cs_n) begin
            if (seen_cmd) begin
                a_r4_min_gap: assert (idle_run >= GAP_W'(GAP_CYC))
                    else $error("command gap too short: %0d", idle_run);
            end
            idle_run <= '0;
            seen_cmd <= 1'b1;
        end else if (idle_run < GAP_W'(GAP_CYC)) begin
            idle_run <= idle_run + 1'b1;
        end
    end

endmodule

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;

    localparam int unsigned CLK_MHZ  = 1;
    localparam int unsigned WAIT_US  = 30;
    localparam int unsigned WAIT_CYC = CLK_MHZ * WAIT_US;
    localparam int unsigned GAP_CYC  = 5;
    localparam int unsigned LIST_LEN = 20;
    localparam int unsigned TOTAL    = 40;
    localparam int unsigned ADDR_W   = 13;
    localparam int unsigned BA_W     = 2;

    // {cl_field[1:0], fast, wide, expected byte[7:0]}
    localparam logic [11:0] VEC [8] = '{
        {2'd0, 1'b1, 1'b1, 8'h40},
        {2'd2, 1'b1, 1'b1, 8'h60},
        {2'd0, 1'b1, 1'b0, 8'h20},
        {2'd3, 1'b1, 1'b0, 8'h30},
        {2'd1, 1'b0, 1'b1, 8'h40},
        {2'd0, 1'b0, 1'b1, 8'h60},
        {2'd1, 1'b0, 1'b0, 8'h20},
        {2'd2, 1'b0, 1'b0, 8'h30}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [1:0]        cfg_cl_field = '0;
    logic              cfg_fast_clk = 1'b1;
    logic              cfg_wide_bus = 1'b1;
    logic [7:0]        cfg_mode_ovr = '0;
    logic              cfg_refresh_on = 1'b1;
    logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [ADDR_W-1:0] sd_addr;
    logic [BA_W-1:0]   sd_ba;
    logic              refresh_en;
    logic              init_done;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned cyc      = 0;

    always #2.5 clk = ~clk;

    sdram_init_seq #(
        .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .GAP_CYC(GAP_CYC),
        .REFRESH_COUNT(8), .PASSES(2), .ADDR_W(ADDR_W), .BA_W(BA_W)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .cfg_cl_field(cfg_cl_field), .cfg_fast_clk(cfg_fast_clk),
        .cfg_wide_bus(cfg_wide_bus), .cfg_mode_ovr(cfg_mode_ovr),
        .cfg_refresh_on(cfg_refresh_on),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
        .refresh_en(refresh_en), .init_done(init_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    // internal code from pins, -1 when deselected, 9 for an illegal pattern
    function automatic int pin_code();
        if (sd_cs_n) return -1;
        case ({sd_ras_n, sd_cas_n, sd_we_n})
            3'b111: return 0;
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 3;
            default: return 9;
        endcase
    endfunction

    function automatic int exp_code(input int unsigned k);
        if (k == 0)          return 3;
        else if (k % 2 != 0) return 0;
        else if (k == 18)    return 1;
        else                 return 2;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_seq(input logic [1:0] cl, input logic fast, input logic wide,
                           input logic [7:0] ovr, input logic refr,
                           input logic [7:0] exp_byte, input string tag);
        int unsigned ncmd = 0;
        int unsigned idle = 0;
        bit          saw_restore = 1'b0;
        do_reset();
        cfg_cl_field   = cl;
        cfg_fast_clk   = fast;
        cfg_wide_bus   = wide;
        cfg_mode_ovr   = ovr;
        cfg_refresh_on = refr;
        pulse_start();
        idle = 1; // cycle of the start pulse itself was deselected
        for (int t = 0; t < 2000; t++) begin
            int code;
            code = pin_code();
            if (code >= 0) begin
                check(code == exp_code(ncmd % LIST_LEN), "R3", "command code", code,
                      exp_code(ncmd % LIST_LEN));
                if (ncmd % LIST_LEN == 0)
                    check(idle >= WAIT_CYC, "R2", "power-up wait", idle, WAIT_CYC);
                else
                    check(idle >= GAP_CYC, "R4", "command gap", idle, GAP_CYC);
                check(!refresh_en, "R6", "refresh during pass", refresh_en, 0);
                if (ncmd == LIST_LEN)
                    check(saw_restore == refr, "R6", "restore between passes",
                          saw_restore, refr);
                if (code == 1) begin
                    check(sd_addr[7:0] == exp_byte, tag, "mode byte", sd_addr[7:0], exp_byte);
                    check(sd_addr[ADDR_W-1:8] == '0 && sd_ba == '0, "R10",
                          "mode load upper address/bank", {sd_addr[ADDR_W-1:8], sd_ba}, 0);
                end
                if (code == 3)
                    check(sd_addr[10] == 1'b1, "R10", "precharge all-banks bit",
                          sd_addr[10], 1);
                ncmd++;
                idle = 0;
            end else begin
                idle++;
                if (refresh_en && ncmd == LIST_LEN) saw_restore = 1'b1;
            end
            if (init_done) break;
            @(negedge clk);
        end
        check(ncmd == TOTAL, "R5", "command count", ncmd, TOTAL);
        check(init_done, "R5", "done raised", init_done, 1);
        check(refresh_en == refr, "R6", "refresh after done", refresh_en, refr);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin : main
        // R1: reset state
        @(negedge clk);
        check(sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n, "R1", "pins in reset",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 15);
        check(!init_done && !refresh_en, "R1", "done/refresh in reset",
              {init_done, refresh_en}, 0);
        do_reset();
        begin
            bit quiet = 1'b1;
            for (int t = 0; t < 60; t++) begin
                @(negedge clk);
                if (!sd_cs_n || init_done || refresh_en) quiet = 1'b0;
            end
            check(quiet, "R1", "idle without start", quiet, 1);
        end

        // table of CL / speed / width combinations (R7, R8)
        for (int i = 0; i < 8; i++) begin
            run_seq(VEC[i][11:10], VEC[i][9], VEC[i][8], 8'h00, i[0],
                    VEC[i][7:0], VEC[i][8] ? "R7" : "R8");
        end

        // R9: override on a wide bus and on a narrow bus (no shift)
        run_seq(2'd0, 1'b1, 1'b1, 8'h5A, 1'b1, 8'h5A, "R9");
        run_seq(2'd3, 1'b0, 1'b0, 8'h5A, 1'b1, 8'h5A, "R9");

        // R11: start after completion is ignored
        begin
            bit quiet = 1'b1;
            pulse_start();
            for (int t = 0; t < 150; t++) begin
                @(negedge clk);
                if (!sd_cs_n || !init_done) quiet = 1'b0;
            end
            check(quiet, "R11", "no commands after done", quiet, 1);
        end

        // R1: reset in the middle of a run
        do_reset();
        pulse_start();
        repeat (WAIT_CYC + 40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(sd_cs_n && !init_done && !refresh_en, "R1", "mid-run reset outputs",
              {sd_cs_n, init_done, refresh_en}, 4);
        rst = 1'b0;
        begin
            bit quiet = 1'b1;
            for (int t = 0; t < 80; t++) begin
                @(negedge clk);
                if (!sd_cs_n || init_done) quiet = 1'b0;
            end
            check(quiet, "R1", "idle after mid-run reset", quiet, 1);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule